// File: doc/BRIEF.md
# Four-Way Interleaved Word Memory

This block is a word memory split into four independent banks. All banks see the same request port and return data over one response port. The two lowest address bits pick a bank and the upper bits pick a word inside it, so consecutive addresses land in consecutive banks. Each bank keeps its own latched word index and data word and runs a fixed multi-cycle access without depending on the other banks. A caller can issue one request per cycle to rotating banks and keep all four accesses in flight at once.

A request whose bank is still busy is stalled: `req_ready` drops and the caller holds the request until the bank frees. Every read returns exactly one response, flagged by `rsp_valid` and tagged with the full request address. Because every access has the same length and at most one request is accepted per cycle, responses leave in the order the reads were accepted.

Top module: `interleaved_mem`

## Requirements
- R1: While reset is held and right after it is released, every bank is idle. `req_ready` is high for any address and `rsp_valid` is low.
- R2: Address bits [1:0] select the bank and bits [ADDR_W-1:2] select the word. Distinct addresses hold distinct words, including two addresses in the same bank.
- R3: Requests to different banks are accepted on consecutive clock edges with `req_ready` high each cycle, even while earlier accesses in other banks are still running.
- R4: After a request is accepted at edge E, its bank is busy until edge E+ACC_CYC. A request to that bank sees `req_ready` low for the ACC_CYC cycles after E and high once E+ACC_CYC has passed.
- R5: A read accepted at edge E shows `rsp_valid` high, with its data on `rsp_data`, in the cycle after edge E+ACC_CYC, and not earlier.
- R6: Responses come out in the order the reads were accepted, at most one per cycle. `rsp_addr` equals the address of the read.
- R7: A write stores `req_wdata` at the addressed word by the end of its access, and it produces no response.
- R8: A read that targets a bank with a write in progress is stalled until that write finishes, and then it returns the newly written data.
- R9: A request presented while `req_valid` is low is ignored. It produces no response and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; bits [1:0] select the bank |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Addressed bank is idle; a request with `req_valid` high is accepted at the next edge |
| rsp_valid | output | 1 | Read data is present on the response outputs |
| rsp_data | output | DATA_W | Read data |
| rsp_addr | output | ADDR_W | Address of the read being answered |

## Verification
Several internal faults show up at the ports within a few cycles. A bank counter that releases too early shows up as `req_ready` rising before ACC_CYC cycles have passed on a same-bank request. A counter that never releases leaves a held request stalled forever. A wrong bank or word decode appears as the wrong data on the next read of an address that was written earlier. A misplaced completion strobe shifts `rsp_valid` by one or more cycles from the expected edge, or returns a tag that does not match the oldest outstanding read. Back-to-back rotating reads expose any lost overlap, because their four responses must arrive in four adjacent cycles.

// File: rtl/interleaved_mem.sv
module interleaved_mem #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int ACC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int SEL_W  = 2;
  localparam int BANKS  = 1 << SEL_W;
  localparam int WORD_W = ADDR_W - SEL_W;
  localparam int DEPTH  = 1 << WORD_W;
  localparam int CNT_W  = $clog2(ACC_CYC + 1);

  logic [SEL_W-1:0]  sel;
  logic              accept;
  logic [BANKS-1:0]  busy;
  logic [BANKS-1:0]  done;
  logic [WORD_W-1:0] bank_word [BANKS];
  logic [DATA_W-1:0] bank_data [BANKS];
  logic [SEL_W-1:0]  done_idx;
  logic [SEL_W-1:0]  rsp_bank;

  assign sel       = req_addr[SEL_W-1:0];
  assign req_ready = !busy[sel];
  assign accept    = req_valid && req_ready;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] store [DEPTH];
    logic [WORD_W-1:0] areg;
    logic [DATA_W-1:0] dreg;
    logic [CNT_W-1:0]  cnt;
    logic              is_wr;
    logic              hit;
    logic              last;

    assign hit  = accept && (sel == SEL_W'(g));
    assign last = (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt   <= '0;
        areg  <= '0;
        dreg  <= '0;
        is_wr <= 1'b0;
      end else if (hit) begin
        cnt   <= CNT_W'(ACC_CYC);
        areg  <= req_addr[ADDR_W-1:SEL_W];
        is_wr <= req_write;
        if (req_write) dreg <= req_wdata;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (last && !is_wr) dreg <= store[areg];
      end
    end

    always_ff @(posedge clk) begin
      if (last && is_wr) store[areg] <= dreg;
    end

    assign busy[g]      = (cnt != '0);
    assign done[g]      = last && !is_wr;
    assign bank_word[g] = areg;
    assign bank_data[g] = dreg;
  end

  always_comb begin
    done_idx = '0;
    for (int b = 0; b < BANKS; b++)
      if (done[b]) done_idx = SEL_W'(b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bank  <= '0;
    end else begin
      rsp_valid <= |done;
      rsp_bank  <= done_idx;
    end
  end

  assign rsp_data = bank_data[rsp_bank];
  assign rsp_addr = {bank_word[rsp_bank], rsp_bank};
endmodule

module interleaved_mem_chk #(
  parameter int ADDR_W  = 8,
  parameter int ACC_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr
);
  localparam int CNT_W = $clog2(ACC_CYC + 1);

  logic [CNT_W-1:0]  tmr [4];
  logic [3:0]        rd_pend;
  logic [ADDR_W-1:0] q [4];
  logic [1:0]        wp, rp;
  logic [2:0]        n;
  logic              acc, push, pop;

  assign acc  = req_valid && req_ready;
  assign push = acc && !req_write;
  assign pop  = rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) tmr[b] <= '0;
      rd_pend <= '0;
      wp <= '0;
      rp <= '0;
      n  <= '0;
      for (int b = 0; b < 4; b++) q[b] <= '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (acc && req_addr[1:0] == 2'(b)) begin
          tmr[b]     <= CNT_W'(ACC_CYC);
          rd_pend[b] <= !req_write;
        end else if (tmr[b] != '0) begin
          tmr[b] <= tmr[b] - 1'b1;
        end
      end
      if (push) begin
        q[wp] <= req_addr;
        wp    <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      n <= n + {2'b0, push} - {2'b0, pop};
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !rsp_valid);

  p_idle_bank_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tmr[req_addr[1:0]] == '0) |-> req_ready);

  p_busy_bank_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr[req_addr[1:0]] != '0) |-> !req_ready);

  p_rsp_has_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (n != '0));

  p_rsp_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr == q[rp]));

  for (genvar g = 0; g < 4; g++) begin : g_lat
    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr[g] == CNT_W'(1) && rd_pend[g]) |=> (rsp_valid && rsp_addr[1:0] == 2'(g)));
  end
endmodule

bind interleaved_mem interleaved_mem_chk #(.ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
);

// File: tb/tb_interleaved_mem.sv
module tb_interleaved_mem;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int ACC_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] rsp_addr;
  int total = 0, bad = 0;

  interleaved_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_addr(rsp_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {write, addr, wdata, expected read data}
  localparam logic [40:0] VEC [13] = '{
    {1'b1, 8'h00, 16'h1111, 16'h0000},
    {1'b1, 8'h01, 16'h2222, 16'h0000},
    {1'b1, 8'h02, 16'h3333, 16'h0000},
    {1'b1, 8'h03, 16'h4444, 16'h0000},
    {1'b1, 8'h04, 16'h5555, 16'h0000},
    {1'b1, 8'hFF, 16'hAAAA, 16'h0000},
    {1'b0, 8'h00, 16'h0000, 16'h1111},
    {1'b0, 8'h04, 16'h0000, 16'h5555},
    {1'b0, 8'h03, 16'h0000, 16'h4444},
    {1'b0, 8'hFF, 16'h0000, 16'hAAAA},
    {1'b1, 8'h00, 16'hBEEF, 16'h0000},
    {1'b0, 8'h00, 16'h0000, 16'hBEEF},
    {1'b0, 8'h01, 16'h0000, 16'h2222}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, output int waits);
    waits = 0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      req_addr = 8'(b); #1;
      chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    end
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);

    // R2 R7 table: writes and single reads, each waited out
    for (int i = 0; i < 13; i++) begin
      do_req(VEC[i][40], VEC[i][39:32], VEC[i][31:16], w);
      repeat (ACC_CYC) @(posedge clk);
      @(negedge clk);
      if (VEC[i][40]) begin
        chk(rsp_valid == 1'b0, "R7 write gives no response", 32'(rsp_valid), 0);
      end else begin
        chk(rsp_valid == 1'b1, "R5 read response valid", 32'(rsp_valid), 1);
        chk(rsp_data == VEC[i][15:0], "R2 read data", 32'(rsp_data), 32'(VEC[i][15:0]));
        chk(rsp_addr == VEC[i][39:32], "R6 response tag", 32'(rsp_addr), 32'(VEC[i][39:32]));
      end
    end

    // R3 R6: four rotating reads back to back
    for (int i = 0; i < 4; i++) begin
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(i); #1;
      chk(req_ready == 1'b1, "R3 ready on rotating bank", 32'(req_ready), 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [15:0] e;
      e = (i == 0) ? 16'hBEEF : (i == 1) ? 16'h2222 : (i == 2) ? 16'h3333 : 16'h4444;
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R6 streamed response valid", 32'(rsp_valid), 1);
      chk(rsp_data == e, "R6 streamed data", 32'(rsp_data), 32'(e));
      chk(rsp_addr == 8'(i), "R6 streamed order", 32'(rsp_addr), i);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R6 no extra response", 32'(rsp_valid), 0);

    // R4 R5: same-bank request held while busy
    do_req(1'b0, 8'h04, '0, w);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
    for (int k = 0; k < ACC_CYC; k++) begin
      #1;
      chk(req_ready == 1'b0, "R4 busy bank stalls", 32'(req_ready), 0);
      if (k < ACC_CYC - 1)
        chk(rsp_valid == 1'b0, "R5 no early response", 32'(rsp_valid), 0);
      @(negedge clk);
    end
    #1;
    chk(req_ready == 1'b1, "R4 bank frees after access", 32'(req_ready), 1);
    chk(rsp_valid == 1'b1 && rsp_data == 16'h5555, "R5 first response on time", 32'(rsp_data), 32'h5555);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R5 second read not early", 32'(rsp_valid), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_data == 16'hBEEF, "R5 second read data", 32'(rsp_data), 32'hBEEF);

    // R8: read behind a write in the same bank
    do_req(1'b1, 8'h02, 16'h7777, w);
    do_req(1'b0, 8'h02, '0, w);
    chk(w == ACC_CYC, "R8 read stalled behind write", w, ACC_CYC);
    repeat (ACC_CYC) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_data == 16'h7777, "R8 read sees new data", 32'(rsp_data), 32'h7777);

    // R9: invalid request ignored
    req_valid = 1'b0; req_write = 1'b1; req_addr = 8'h01; req_wdata = 16'hDEAD;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9 idle port quiet", 32'(rsp_valid), 0);
    end
    do_req(1'b0, 8'h01, '0, w);
    repeat (ACC_CYC) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_data == 16'h2222, "R9 word unchanged", 32'(rsp_data), 32'h2222);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule